// File: doc/BRIEF.md
# Return Address Stack with Interrupt Gating

This block keeps the return addresses of a small microcontroller core. When the core calls a subroutine or acknowledges an interrupt, it presents the current program counter and raises the push strobe. When it executes a return or a return-from-interrupt, it raises the pop strobe, and the saved address appears on the output one cycle later. The stack and its pointer cannot be reached by software; the only way to affect them is through the strobes.

The block also decides whether a pending interrupt may be acknowledged. While all entries are occupied, acknowledges are held off and the request stays pending at the interrupt controller. A return frees an entry, and the permit reopens in the next cycle. A subroutine call is never held off. A call made on a full stack overwrites the oldest return address, so the newest addresses are always kept.

Popping an empty stack leaves the pointer where it is and leaves the output unchanged. It also raises a one-cycle underflow pulse.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, full_o is 0, underflow_o is 0, pc_o is 0 and the stack holds no entries.
- R2: A push stores pc_i. A pop puts the most recently stored remaining entry on pc_o in the cycle after the pop strobe. Entries come back in last-in, first-out order. push_i and pop_i are never high in the same cycle.
- R3: The stack holds up to DEPTH entries (default 16). full_o is 1 exactly while DEPTH entries are stored.
- R4: A push while full discards the oldest entry, so the DEPTH most recent addresses remain and can be popped in reverse order of pushing.
- R5: A pop while empty leaves pc_o unchanged and the stack empty, and drives underflow_o to 1 for exactly the following cycle. underflow_o is 0 in every other cycle.
- R6: ack_en_o equals irq_pend_i AND NOT full_o, combinationally in the same cycle.
- R7: An interrupt held off by a full stack gets ack_en_o = 1 in the cycle after a pop takes the stack below full, if it is still pending.
- R8: The program counter width is the parameter PC_W (default 13). All PC_W bits, including an all-ones address, are stored and returned unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save pc_i (call or interrupt acknowledge) |
| pop_i | input | 1 | Restore top entry (return or return-from-interrupt) |
| pc_i | input | PC_W | Program counter to save |
| pc_o | output | PC_W | Most recently restored return address |
| full_o | output | 1 | All entries occupied |
| underflow_o | output | 1 | One-cycle pulse after a pop of an empty stack |
| irq_pend_i | input | 1 | An unmasked interrupt request is pending |
| ack_en_o | output | 1 | Interrupt acknowledge permitted |

## Verification
The hardest corner to reach is the wrapped stack. In that state the write index has lapped the oldest entry, and the stack must then be drained past its limit. The stimulus pushes twenty distinct addresses so that four old entries are overwritten. It then pops seventeen times, so the sixteen survivors return in reverse order and the last pop underflows. Interrupt pending is held high through the full phase and the first pop, which exposes the one-cycle reopening of the permit. A long random run of non-overlapping strobes then compares every cycle against a queue model.

// File: rtl/ras_pkg.sv
package ras_pkg;

   // Width needed to index DEPTH entries.
   function automatic int unsigned idx_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

   // Width needed to count 0..DEPTH inclusive.
   function automatic int unsigned cnt_bits(input int unsigned depth);
      return $clog2(depth + 1);
   endfunction

   typedef enum logic [1:0] {
      OP_IDLE = 2'b00,
      OP_PUSH = 2'b01,
      OP_POP  = 2'b10
   } ras_op_e;

endpackage

// File: rtl/ras_occupancy.sv
module ras_occupancy
   import ras_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW = idx_bits(DEPTH),
   localparam int unsigned CW = cnt_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic          pop_i,
   output logic [AW-1:0] wr_idx_o,
   output logic [AW-1:0] rd_idx_o,
   output logic          rd_en_o,
   output logic [CW-1:0] cnt_o,
   output logic          full_o,
   output logic          underflow_o
);

   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
   localparam logic [AW-1:0] IDX_LAST = AW'(DEPTH - 1);

   logic [AW-1:0] top_q;
   logic [CW-1:0] cnt_q;
   logic          uf_q;
   ras_op_e       op;
   logic          empty;
   logic [AW-1:0] top_inc;
   logic [AW-1:0] top_dec;

   assign empty = (cnt_q == '0);

   always_comb begin
      unique case ({pop_i, push_i})
         2'b01:   op = OP_PUSH;
         2'b10:   op = OP_POP;
         default: op = OP_IDLE;
      endcase
   end

   // Pointer wraps modulo DEPTH (DEPTH need not be a power of two).
   assign top_inc = (top_q == IDX_LAST) ? '0 : top_q + AW'(1);
   assign top_dec = (top_q == '0) ? IDX_LAST : top_q - AW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= '0;
         cnt_q <= '0;
         uf_q  <= 1'b0;
      end else begin
         uf_q <= 1'b0;
         unique case (op)
            OP_PUSH: begin
               top_q <= top_inc;
               if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
            end
            OP_POP: begin
               if (empty) begin
                  uf_q <= 1'b1;
               end else begin
                  top_q <= top_dec;
                  cnt_q <= cnt_q - CW'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign wr_idx_o    = top_q;
   assign rd_idx_o    = top_dec;
   assign rd_en_o     = (op == OP_POP) && !empty;
   assign cnt_o       = cnt_q;
   assign full_o      = (cnt_q == CNT_MAX);
   assign underflow_o = uf_q;

endmodule

// File: rtl/ras_storage.sv
module ras_storage
   import ras_pkg::*;
#(
   parameter int unsigned PC_W        = 13,
   parameter int unsigned DEPTH       = 16,
   parameter bit          RESET_ARRAY = 1'b1,
   localparam int unsigned AW = idx_bits(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [AW-1:0]   wr_idx_i,
   input  logic [PC_W-1:0] wr_data_i,
   input  logic            rd_en_i,
   input  logic [AW-1:0]   rd_idx_i,
   output logic [PC_W-1:0] rd_data_o
);

   logic [PC_W-1:0] slot_q [DEPTH];
   logic [PC_W-1:0] rd_q;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      logic hit;
      assign hit = wr_en_i && (wr_idx_i == AW'(e));
      if (RESET_ARRAY) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   slot_q[e] <= '0;
            else if (hit) slot_q[e] <= wr_data_i;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (hit) slot_q[e] <= wr_data_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_q <= '0;
      else if (rd_en_i) rd_q <= slot_q[rd_idx_i];
   end

   assign rd_data_o = rd_q;

endmodule

// File: rtl/ras_irq_gate.sv
module ras_irq_gate (
   input  logic irq_pend_i,
   input  logic full_i,
   output logic ack_en_o
);

   // Acknowledge needs a free entry for the pushed PC; the request stays
   // pending upstream while this is low.
   assign ack_en_o = irq_pend_i && !full_i;

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int unsigned PC_W        = 13,
   parameter int unsigned DEPTH       = 16,
   parameter bit          RESET_ARRAY = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [PC_W-1:0] pc_i,
   output logic [PC_W-1:0] pc_o,
   output logic            full_o,
   output logic            underflow_o,
   input  logic            irq_pend_i,
   output logic            ack_en_o
);

   localparam int unsigned AW = idx_bits(DEPTH);
   localparam int unsigned CW = cnt_bits(DEPTH);

   initial begin
      if (PC_W < 1 || PC_W > 32)
         $error("ret_addr_stack: PC_W must be 1..32");
      if (DEPTH < 2 || DEPTH > 256)
         $error("ret_addr_stack: DEPTH must be 2..256");
   end

   logic [AW-1:0] wr_idx;
   logic [AW-1:0] rd_idx;
   logic          rd_en;
   logic [CW-1:0] occ_cnt;
   logic          full;

   ras_occupancy #(.DEPTH(DEPTH)) u_occ (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .pop_i       (pop_i),
      .wr_idx_o    (wr_idx),
      .rd_idx_o    (rd_idx),
      .rd_en_o     (rd_en),
      .cnt_o       (occ_cnt),
      .full_o      (full),
      .underflow_o (underflow_o)
   );

   ras_storage #(
      .PC_W        (PC_W),
      .DEPTH       (DEPTH),
      .RESET_ARRAY (RESET_ARRAY)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (push_i && !pop_i),
      .wr_idx_i  (wr_idx),
      .wr_data_i (pc_i),
      .rd_en_i   (rd_en),
      .rd_idx_i  (rd_idx),
      .rd_data_o (pc_o)
   );

   ras_irq_gate u_gate (
      .irq_pend_i (irq_pend_i),
      .full_i     (full),
      .ack_en_o   (ack_en_o)
   );

   assign full_o = full;

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
   parameter int unsigned PC_W  = 13,
   parameter int unsigned CW    = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic            push_i,
   input logic            pop_i,
   input logic [PC_W-1:0] pc_o,
   input logic            full_o,
   input logic            underflow_o,
   input logic            irq_pend_i,
   input logic            ack_en_o,
   input logic [CW-1:0]   occ_cnt
);

   // R2
   no_push_pop_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(push_i && pop_i));

   // R6
   no_ack_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !ack_en_o);

   // R6
   ack_when_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pend_i && !full_o) |-> ack_en_o);

   // R5
   empty_pop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && occ_cnt == '0) |=> (underflow_o && $stable(pc_o) && occ_cnt == '0));

   // R5
   underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop_i || occ_cnt != '0) |=> !underflow_o);

   // R4
   full_stays_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && push_i) |=> full_o);

   // R7
   pop_reopens_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full_o && pop_i) |=> !full_o);

endmodule

bind ret_addr_stack ras_chk #(.PC_W(PC_W), .CW(CW)) u_ras_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .pc_o        (pc_o),
   .full_o      (full_o),
   .underflow_o (underflow_o),
   .irq_pend_i  (irq_pend_i),
   .ack_en_o    (ack_en_o),
   .occ_cnt     (occ_cnt)
);

// File: tb/ret_addr_stack_test.sv
`timescale 1ns/100ps
module ret_addr_stack_test;

   localparam int PC_W  = 13;
   localparam int DEPTH = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            push_i = 1'b0;
   logic            pop_i = 1'b0;
   logic [PC_W-1:0] pc_i = '0;
   logic [PC_W-1:0] pc_o;
   logic            full_o;
   logic            underflow_o;
   logic            irq_pend_i = 1'b0;
   logic            ack_en_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ret_addr_stack #(.PC_W(PC_W), .DEPTH(DEPTH)) uut (.*);

   // Behavioural reference: a queue of addresses, newest at the back.
   logic [PC_W-1:0] model_q[$];
   logic [PC_W-1:0] exp_pc = '0;
   bit              exp_uf = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         model_q.delete();
         exp_pc = '0;
         exp_uf = 1'b0;
      end else begin
         exp_uf = 1'b0;
         if (push_i) begin
            if (model_q.size() == DEPTH) void'(model_q.pop_front());
            model_q.push_back(pc_i);
         end else if (pop_i) begin
            if (model_q.size() == 0) exp_uf = 1'b1;
            else exp_pc = model_q.pop_back();
         end
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Compare every cycle, 1 ns after the falling edge.
   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         check("R2/R4/R8", "pc_o", 32'(pc_o), 32'(exp_pc));
         check("R3", "full_o", 32'(full_o), 32'(model_q.size() == DEPTH));
         check("R5", "underflow_o", 32'(underflow_o), 32'(exp_uf));
         check("R6/R7", "ack_en_o", 32'(ack_en_o),
               32'(irq_pend_i && model_q.size() != DEPTH));
      end
   end

   task automatic step(input bit psh, input bit pp, input logic [PC_W-1:0] pc);
      @(negedge clk);
      push_i = psh;
      pop_i  = pp;
      pc_i   = pc;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset values while held in reset
      check("R1", "reset pc_o", 32'(pc_o), 32'h0);
      check("R1", "reset full_o", 32'(full_o), 32'h0);
      check("R1", "reset underflow_o", 32'(underflow_o), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: simple LIFO run, with all-ones address for R8
      step(1, 0, 13'h0123);
      step(1, 0, 13'h1FFF);
      step(1, 0, 13'h0A55);
      for (int i = 0; i < 3; i++) step(0, 1, '0);
      step(0, 0, '0);
      // R5: pops of an empty stack, back to back and separated
      step(0, 1, '0);
      step(0, 1, '0);
      step(0, 0, '0);
      step(0, 1, '0);
      step(0, 0, '0);

      // R3/R4/R6/R7: overflow with interrupt pending throughout
      irq_pend_i = 1'b1;
      for (int i = 0; i < 20; i++) step(1, 0, PC_W'(13'h0100 + i * 13'h0011));
      step(0, 0, '0);
      for (int i = 0; i < 17; i++) step(0, 1, '0);
      step(0, 0, '0);
      irq_pend_i = 1'b0;

      // R3: fill exactly to DEPTH, then one pop
      for (int i = 0; i < DEPTH; i++) step(1, 0, PC_W'(13'h1000 + i));
      step(0, 0, '0);
      step(0, 1, '0);
      step(0, 0, '0);
      for (int i = 0; i < DEPTH; i++) step(0, 1, '0);

      // Random mix, never push and pop together
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         irq_pend_i = ($urandom_range(0, 1) == 1);
         if (r < 5)      step(1, 0, PC_W'($urandom));
         else if (r < 9) step(0, 1, '0);
         else            step(0, 0, '0);
      end
      step(0, 0, '0);
      repeat (2) @(negedge clk);
      #2;
      finish_run();
   end

endmodule